// File: doc/BRIEF.md
# Accelerator Configuration Fetch Sequencer

This block fetches three configuration words from an accelerator's register space over a simple read-request channel. It then turns them into a buffer descriptor for the logic downstream. After a start pulse it reads three words in a fixed order:

- a "descriptor valid" word,
- the base address of an output buffer in external memory,
- the size of that buffer.

Each read goes out as an address, a byte length and an address-valid strobe. The request is held until the responder shows address-ready. The block then waits for a data-valid response, captures the returned word and moves to the next address.

When the third word arrives and the valid word was non-zero, the block presents the fetched address and size with a qualifying valid flag. That flag rises on the cycle after the final response. If the valid word was zero, the accelerator is not ready yet. In that case the block stays silent for a programmable number of cycles and then repeats the whole series. A start pulse while a descriptor is presented withdraws it and begins a fresh fetch.

Top module: `cfg_fetch_seq`

## Requirements
- R1: While reset is held and after its release, `req_avalid` and `buf_valid` are 0, and `buf_addr` and `buf_size` are 0.
- R2: A request stays asserted, with a stable address, until `rsp_aready` is sampled high at a clock edge; it is deasserted in the cycle after that edge.
- R3: Every request carries `req_len` equal to 4 (bytes).
- R4: The three reads go to offsets 0x354 (valid word), 0x358 (buffer address) and 0x35C (buffer size), in that order. No new request is raised before the data-valid response of the previous read has been sampled.
- R5: When the valid word is non-zero, `buf_valid` rises in the cycle after the edge that samples the final `rsp_dvalid`. At that point `buf_addr` equals the word returned from 0x358 and `buf_size` equals the word returned from 0x35C. All three then hold with no further requests until a new start.
- R6: When the valid word is zero, `buf_valid` stays 0 and `req_avalid` stays low for exactly RETRY_DLY cycles after the final response. The series then restarts at 0x354.
- R7: A start pulse while a fetch series is in progress is ignored; the address order and the presented result are unchanged.
- R8: A start pulse while `buf_valid` is high drops `buf_valid` in the next cycle and raises a new request to 0x354 in the same cycle. `buf_addr` and `buf_size` keep their old values until the new series completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch series (single-cycle pulse) |
| req_addr | output | ADDR_W | Register offset of the current read |
| req_len | output | LEN_W | Byte length of the current read (always 4) |
| req_avalid | output | 1 | Request address/length valid |
| rsp_aready | input | 1 | Responder accepted the request |
| rsp_dvalid | input | 1 | Response word valid |
| rsp_data | input | DATA_W | Returned register word |
| buf_addr | output | DATA_W | Fetched output-buffer base address |
| buf_size | output | DATA_W | Fetched output-buffer size |
| buf_valid | output | 1 | Qualifies `buf_addr` and `buf_size` |

## Verification
The bench builds the block with RETRY_DLY set to 5 and the default base offset and stride. The short back-off lets several retry rounds fit in a short run, so the exact length of the quiet gap can be counted cycle by cycle. The responder's accept and response latencies are varied from zero to several cycles, which covers both back-to-back handshakes and long request holds. Start pulses are placed both mid-series and while a descriptor is presented.

// File: rtl/cfg_fetch_pkg.sv
package cfg_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_HOLD,
    ST_BACKOFF
  } fetch_state_e;

  // word slots in fetch order; order is behaviour (valid first, size last)
  localparam int unsigned SLOT_VALID = 0;
  localparam int unsigned SLOT_ADDR  = 1;
  localparam int unsigned SLOT_SIZE  = 2;
  localparam int unsigned N_SLOTS    = 3;

  // register offset of a slot: base plus a fixed stride per slot
  function automatic logic [31:0] slot_offset(input logic [31:0] base,
                                              input logic [31:0] stride,
                                              input logic [1:0]  slot);
    return base + stride * {30'd0, slot};
  endfunction

  function automatic logic slot_is_last(input logic [1:0] slot);
    return slot == 2'(N_SLOTS - 1);
  endfunction

endpackage

// File: rtl/cfg_fetch_backoff.sv
module cfg_fetch_backoff #(
  parameter int unsigned DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int unsigned CNT_W = (DLY < 2) ? 1 : $clog2(DLY);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign expire = busy && (cnt == CNT_W'(DLY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (expire) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_fetch_capture.sv
module cfg_fetch_capture
  import cfg_fetch_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        slot,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              publish,
  input  logic              withdraw,
  output logic              valid_nz,
  output logic [DATA_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_size,
  output logic              buf_valid
);
  logic [DATA_W-1:0] valid_word;
  logic [DATA_W-1:0] addr_word;

  assign valid_nz = |valid_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_word <= '0;
      addr_word  <= '0;
    end else if (cap_en) begin
      if (slot == 2'(SLOT_VALID)) valid_word <= rsp_data;
      if (slot == 2'(SLOT_ADDR))  addr_word  <= rsp_data;
    end
  end

  // size comes straight from the final response so the result is out one cycle later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_addr  <= '0;
      buf_size  <= '0;
      buf_valid <= 1'b0;
    end else if (publish) begin
      buf_addr  <= addr_word;
      buf_size  <= rsp_data;
      buf_valid <= 1'b1;
    end else if (withdraw) begin
      buf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_fetch_ctrl.sv
module cfg_fetch_ctrl
  import cfg_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rsp_aready,
  input  logic       rsp_dvalid,
  input  logic       valid_nz,
  input  logic       backoff_expire,
  output logic       req_avalid,
  output logic [1:0] slot,
  output logic       cap_en,
  output logic       fetch_done,
  output logic       retry_load,
  output logic       withdraw
);
  fetch_state_e state, state_nxt;
  logic [1:0]   slot_nxt;

  always_comb begin
    state_nxt  = state;
    slot_nxt   = slot;
    req_avalid = 1'b0;
    cap_en     = 1'b0;
    fetch_done = 1'b0;
    retry_load = 1'b0;
    withdraw   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          state_nxt = ST_REQ;
          slot_nxt  = 2'd0;
        end
      end
      ST_REQ: begin
        req_avalid = 1'b1;
        if (rsp_aready) state_nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_dvalid) begin
          cap_en = 1'b1;
          if (slot_is_last(slot)) begin
            if (valid_nz) begin
              fetch_done = 1'b1;
              state_nxt  = ST_HOLD;
            end else begin
              retry_load = 1'b1;
              state_nxt  = ST_BACKOFF;
            end
          end else begin
            slot_nxt  = slot + 2'd1;
            state_nxt = ST_REQ;
          end
        end
      end
      ST_HOLD: begin
        if (start) begin
          withdraw  = 1'b1;
          slot_nxt  = 2'd0;
          state_nxt = ST_REQ;
        end
      end
      ST_BACKOFF: begin
        if (backoff_expire) begin
          slot_nxt  = 2'd0;
          state_nxt = ST_REQ;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= 2'd0;
    end else begin
      state <= state_nxt;
      slot  <= slot_nxt;
    end
  end
endmodule

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
  import cfg_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned RD_BYTES  = 4,
  parameter int unsigned BASE_OFS  = 32'h354,
  parameter int unsigned STRIDE    = 4,
  parameter int unsigned RETRY_DLY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              req_avalid,
  input  logic              rsp_aready,
  input  logic              rsp_dvalid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_size,
  output logic              buf_valid
);
  localparam logic [LEN_W-1:0] LEN_CONST = LEN_W'(RD_BYTES);

  // internal events, named for the checker
  logic [1:0]  slot;
  logic        cap_en;
  logic        fetch_done;
  logic        retry_load;
  logic        withdraw;
  logic        valid_nz;
  logic        backoff_expire;
  logic [31:0] ofs_full;

  assign ofs_full = slot_offset(32'(BASE_OFS), 32'(STRIDE), slot);
  assign req_addr = ofs_full[ADDR_W-1:0];
  assign req_len  = LEN_CONST;

  cfg_fetch_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .rsp_aready     (rsp_aready),
    .rsp_dvalid     (rsp_dvalid),
    .valid_nz       (valid_nz),
    .backoff_expire (backoff_expire),
    .req_avalid     (req_avalid),
    .slot           (slot),
    .cap_en         (cap_en),
    .fetch_done     (fetch_done),
    .retry_load     (retry_load),
    .withdraw       (withdraw)
  );

  cfg_fetch_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .slot      (slot),
    .rsp_data  (rsp_data),
    .publish   (fetch_done),
    .withdraw  (withdraw),
    .valid_nz  (valid_nz),
    .buf_addr  (buf_addr),
    .buf_size  (buf_size),
    .buf_valid (buf_valid)
  );

  cfg_fetch_backoff #(.DLY(RETRY_DLY)) u_backoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (retry_load),
    .expire (backoff_expire)
  );
endmodule

// File: rtl/cfg_fetch_seq_chk.sv
module cfg_fetch_seq_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned RD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_avalid,
  input logic              rsp_aready,
  input logic              rsp_dvalid,
  input logic [DATA_W-1:0] buf_addr,
  input logic [DATA_W-1:0] buf_size,
  input logic              buf_valid,
  input logic              fetch_done,
  input logic              retry_load
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !req_avalid && !buf_valid);

  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_avalid && !rsp_aready |=> req_avalid && $stable(req_addr));

  p_drop_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_avalid && rsp_aready |=> !req_avalid);

  p_len_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_avalid |-> req_len == LEN_W'(RD_BYTES));

  p_rise_after_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> $past(rsp_dvalid));

  p_done_publishes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> buf_valid);

  p_result_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !start |=> buf_valid && $stable(buf_addr) && $stable(buf_size));

  p_retry_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_load |=> !req_avalid && !buf_valid);

  p_valid_excl_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> !req_avalid);
endmodule

bind cfg_fetch_seq cfg_fetch_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .RD_BYTES(RD_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_avalid (req_avalid),
  .rsp_aready (rsp_aready),
  .rsp_dvalid (rsp_dvalid),
  .buf_addr   (buf_addr),
  .buf_size   (buf_size),
  .buf_valid  (buf_valid),
  .fetch_done (fetch_done),
  .retry_load (retry_load)
);

// File: tb/tb_cfg_fetch_seq.sv
module tb_cfg_fetch_seq;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = 8;
  localparam int unsigned DLY    = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              req_avalid;
  logic              rsp_aready = 1'b0;
  logic              rsp_dvalid = 1'b0;
  logic [DATA_W-1:0] rsp_data = '0;
  logic [DATA_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_size;
  logic              buf_valid;

  always #2.5 clk = ~clk;

  cfg_fetch_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .RETRY_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_addr(req_addr), .req_len(req_len), .req_avalid(req_avalid),
    .rsp_aready(rsp_aready), .rsp_dvalid(rsp_dvalid), .rsp_data(rsp_data),
    .buf_addr(buf_addr), .buf_size(buf_size), .buf_valid(buf_valid)
  );

  typedef struct { logic [DATA_W-1:0] a; logic [DATA_W-1:0] s; } desc_t;
  desc_t exp_q[$];

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: every rising edge of buf_valid must match the next expected descriptor
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n && buf_valid && !prev_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected descriptor", 1, 0);
      end else begin
        desc_t e;
        e = exp_q.pop_front();
        chk(buf_addr == e.a, "R5", "buf_addr", buf_addr, e.a);
        chk(buf_size == e.s, "R5", "buf_size", buf_size, e.s);
      end
    end
    prev_valid = rst_n ? buf_valid : 1'b0;
  end

  // responder for one read; entered and left at a falling edge
  task automatic serve(input logic [ADDR_W-1:0] exp_addr, input logic [DATA_W-1:0] word,
                       input int ar_dly, input int dv_dly, input bit poke_start);
    logic [ADDR_W-1:0] first_addr;
    int n = 0;
    while (!req_avalid && n < 60) begin
      n++;
      @(negedge clk);
    end
    chk(req_avalid, "R4", "request raised", req_avalid, 1);
    chk(req_addr == exp_addr, "R4", "request address", req_addr, exp_addr);
    chk(req_len == 8'd4, "R3", "request length", req_len, 4);
    first_addr = req_addr;
    for (int i = 0; i < ar_dly; i++) begin
      if (poke_start && i == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(req_avalid && req_addr == first_addr, "R2", "request held", req_addr, first_addr);
    end
    rsp_aready = 1'b1;
    @(negedge clk);
    rsp_aready = 1'b0;
    chk(!req_avalid, "R2", "request dropped after accept", req_avalid, 0);
    for (int i = 0; i < dv_dly; i++) begin
      @(negedge clk);
      chk(!req_avalid, "R4", "no request before response", req_avalid, 0);
    end
    rsp_dvalid = 1'b1;
    rsp_data   = word;
    @(negedge clk);
    rsp_dvalid = 1'b0;
    rsp_data   = '0;
  endtask

  // driver: full series of three reads
  task automatic fetch(input logic [DATA_W-1:0] vw, input logic [DATA_W-1:0] a,
                       input logic [DATA_W-1:0] s, input int ar, input int dv,
                       input bit poke_mid);
    serve(12'h354, vw, ar, dv, 1'b0);
    serve(12'h358, a, (poke_mid && ar == 0) ? 1 : ar, dv, poke_mid);
    if (vw != 0) exp_q.push_back('{a: a, s: s});
    serve(12'h35C, s, ar, dv, 1'b0);
    if (vw != 0) begin
      chk(buf_valid, "R5", "valid one cycle after final response", buf_valid, 1);
    end else begin
      int n = 0;
      while (!req_avalid && n < 100) begin
        n++;
        chk(!buf_valid, "R6", "no descriptor for zero valid word", buf_valid, 0);
        @(negedge clk);
      end
      chk(n == DLY, "R6", "back-off gap length", n, DLY);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_avalid && !buf_valid, "R1", "outputs in reset", {req_avalid, buf_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(buf_addr == 0 && buf_size == 0 && !buf_valid, "R1", "outputs after reset",
        buf_addr | buf_size, 0);
    chk(!req_avalid, "R1", "no request before start", req_avalid, 0);

    // R4 R5: basic series, zero latencies
    start = 1'b1; @(negedge clk); start = 1'b0;
    fetch(32'h1, 32'h8000_1000, 32'h0000_C000, 0, 0, 1'b0);
    repeat (4) @(negedge clk);
    chk(buf_valid && !req_avalid, "R5", "descriptor held, no requests", req_avalid, 0);

    // R8: restart while presented; old values stay until the new result
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(!buf_valid, "R8", "valid withdrawn", buf_valid, 0);
    chk(req_avalid && req_addr == 12'h354, "R8", "new request to first offset", req_addr, 12'h354);
    chk(buf_addr == 32'h8000_1000, "R8", "old address kept", buf_addr, 32'h8000_1000);
    // R6: zero valid word, long latencies, then retry succeeds
    fetch(32'h0, 32'hDEAD_0000, 32'h0000_0100, 3, 2, 1'b0);
    chk(buf_size == 32'h0000_C000, "R8", "old size kept during retry", buf_size, 32'h0000_C000);
    fetch(32'h0, 32'h1111_0000, 32'h0000_0200, 1, 0, 1'b0);
    fetch(32'hA5, 32'h4000_2000, 32'h0001_0000, 2, 4, 1'b0);

    // R7: start pulsed mid-series is ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    fetch(32'h7, 32'h0000_0040, 32'h0000_0880, 0, 1, 1'b1);
    repeat (3) @(negedge clk);
    chk(buf_valid && buf_addr == 32'h0000_0040, "R7", "result after mid-series start",
        buf_addr, 32'h0000_0040);

    chk(exp_q.size() == 0, "R5", "all descriptors seen", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule